// File: doc/BRIEF.md
# Daisy-Chain Converter Serial Port with Ready Indication

This block is the digital serial side of a single 14-bit sampling converter. Several copies can be wired in a chain: each copy's serial output feeds the next copy's serial input, and the copy nearest the host drives the host's data line. The host controls the chain with a convert line (`cnv`) and a serial clock (`sck`). The conversion itself is modelled as a fixed number of system clock cycles. When that time has passed, the 14-bit `result` input is captured into the port's shift register.

A conversion begins when `cnv` rises while `sck` is high. This also selects chain operation with a ready indication. `sdo` stays low while the local conversion runs. After that, `sdo` follows the incoming `sdi` level. The chain output therefore goes high only once every converter upstream has finished, and that rising level tells the host it can start reading. Each falling `sck` edge advances the data by one bit. The host first sees the local word, most significant bit first, and then the words of the upstream devices. N devices need 14·N+1 falling edges. The host ends the frame by pulling `cnv` low.

`cnv`, `sck` and `sdi` are asynchronous. They are synchronised into the `clk` domain, and their edges are detected there.

Top module: `chain_adc_port`

## Requirements
- R1: While the synchronised `cnv` and `sdi` are both low, `sdo` is low. In idle, `sdo` is always low.
- R2: A conversion starts only on a rising `cnv` edge that is seen while `sck` is high. A `cnv` rise while `sck` is low leaves the port idle, and `sdo` stays low.
- R3: During a conversion `sdo` is low. The conversion lasts exactly CONV_CYCLES system clock cycles.
- R4: After the conversion ends and before the first falling `sck` edge, `sdo` equals the synchronised `sdi` level (local ready = 1, ANDed with upstream ready). `sdo` is therefore high only once all upstream devices have finished.
- R5: The first falling `sck` edge consumes the leading ready bit. After falling edge k (1 ≤ k ≤ 14), `sdo` shows result bit 14−k, so the word goes out MSB first.
- R6: Starting with the second falling edge, each falling edge shifts the synchronised `sdi` into the low end of the data register. After falling edge 14+k, `sdo` shows the bit that the upstream device showed after its falling edge k. A chain of N devices therefore delivers its data in 14·N+1 edges.
- R7: When `cnv` goes low during a conversion or a readback, the port returns to idle, and `sdo` goes low.
- R8: `result` is sampled once, at the end of the conversion. Later changes to `result` do not alter the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv | input | 1 | Convert request, held high through conversion and readback |
| sck | input | 1 | Serial clock; data advances on its falling edge |
| sdi | input | 1 | Serial input from the upstream device (tied to `cnv` at the far end) |
| result | input | DATA_W | Parallel conversion result from the converter core |
| sdo | output | 1 | Serial output: ready level, then shifted data |

## Verification
The bench builds a three-device chain. The three devices have different conversion times, so the ready level at the near end shows whether the slowest upstream device gates it, and not the local timer. The result patterns are all zeros, all ones, the two alternating codes and several arithmetic mixes. These patterns show bit order, word boundaries and the pass-through of upstream words over all 43 edges. `result` is inverted right after capture, which tells sample-once behaviour apart from a live read. Separate runs cover a `cnv` rise with `sck` low, an aborted conversion, and an upstream `sdi` pulled low during the ready phase. Together these separate edge qualification, abort handling and the AND of the ready bit with `sdi`.

// File: rtl/chain_adc_port.sv
module chain_adc_port #(
  parameter int DATA_W      = 14,
  parameter int CONV_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv,
  input  logic              sck,
  input  logic              sdi,
  input  logic [DATA_W-1:0] result,
  output logic              sdo
);
  localparam int SR_W = DATA_W + 1;
  localparam int TW   = $clog2(CONV_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_READ} st_t;

  logic [1:0]      cnv_m, sck_m, sdi_m;
  logic            cnv_d, sck_d;
  st_t             state;
  logic [TW-1:0]   timer;
  logic [SR_W-1:0] shreg;

  wire cnv_s     = cnv_m[1];
  wire sck_s     = sck_m[1];
  wire sdi_s     = sdi_m[1];
  wire cnv_rise  = cnv_s & ~cnv_d;
  wire sck_fall  = sck_d & ~sck_s;
  wire ready_bit = shreg[SR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_m <= '0;
      sck_m <= '0;
      sdi_m <= '0;
      cnv_d <= 1'b0;
      sck_d <= 1'b0;
    end else begin
      cnv_m <= {cnv_m[0], cnv};
      sck_m <= {sck_m[0], sck};
      sdi_m <= {sdi_m[0], sdi};
      cnv_d <= cnv_s;
      sck_d <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      timer <= '0;
      shreg <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          shreg <= '0;
          if (cnv_rise && sck_s) begin
            state <= S_CONV;
            timer <= TW'(CONV_CYCLES - 1);
          end
        end
        S_CONV: begin
          if (!cnv_s) state <= S_IDLE;
          else if (timer == '0) begin
            state <= S_READ;
            shreg <= {1'b1, result};
          end else timer <= timer - 1'b1;
        end
        S_READ: begin
          if (!cnv_s) begin
            state <= S_IDLE;
            shreg <= '0;
          end else if (sck_fall) begin
            if (ready_bit) shreg[SR_W-1] <= 1'b0;
            else shreg[DATA_W-1:0] <= {shreg[DATA_W-2:0], sdi_s};
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign sdo = cnv_s && (state == S_READ) && (ready_bit ? sdi_s : shreg[DATA_W-1]);

  logic [TW:0] conv_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conv_len <= '0;
    else if (state == S_CONV) conv_len <= conv_len + 1'b1;
    else if (state == S_IDLE) conv_len <= '0;
  end

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnv_s && !sdi_s) |-> !sdo);

  p_start_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && cnv_rise && !sck_s) |=> state == S_IDLE);

  p_start_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && cnv_rise && sck_s) |=> state == S_CONV);

  p_conv_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CONV) |-> !sdo);

  p_conv_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_READ && $past(state) == S_CONV) |-> conv_len == (TW+1)'(CONV_CYCLES));

  p_ready_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_READ && ready_bit && cnv_s) |-> sdo == sdi_s);

  p_first_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_READ && ready_bit && sck_fall && cnv_s) |=> (!cnv_s || sdo == $past(shreg[DATA_W-1])));

  p_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_READ && !ready_bit && sck_fall && cnv_s) |=> (!cnv_s || sdo == $past(shreg[DATA_W-2])));

  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnv_s && state != S_IDLE) |=> state == S_IDLE);
endmodule

// File: tb/chain_adc_port_test.sv
`timescale 1ns/1ps
module chain_adc_port_test;
  localparam int DW = 14;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnv = 1'b0, sck = 1'b1, sdi_far = 1'b0;
  logic [DW-1:0] res_far = '0, res_mid = '0, res_near = '0;
  logic sdo_far, sdo_mid, sdo;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chain_adc_port #(.DATA_W(DW), .CONV_CYCLES(60)) u_far (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(sdi_far), .result(res_far), .sdo(sdo_far));
  chain_adc_port #(.DATA_W(DW), .CONV_CYCLES(40)) u_mid (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(sdo_far), .result(res_mid), .sdo(sdo_mid));
  chain_adc_port #(.DATA_W(DW), .CONV_CYCLES(20)) uut (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(sdo_mid), .result(res_near), .sdo(sdo));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic got, input logic exp, input string req, input int idx);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s step %0d: sdo=%b expected %b", req, idx, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] pattern(input int k);
    case (k)
      0: return '0;
      1: return '1;
      2: return 14'h2AAA;
      3: return 14'h1555;
      default: return DW'((k * 32'h2F1B) ^ (k << 7) ^ 32'h0A5);
    endcase
  endfunction

  task automatic run_frame(input int p);
    logic [DW-1:0] w [3];
    w[0] = pattern(p); w[1] = pattern(p + 3); w[2] = pattern(p + 5);
    res_near = w[0]; res_mid = w[1]; res_far = w[2];
    sck = 1'b1; tick(4);
    cnv = 1'b1; sdi_far = 1'b1;
    tick(50);
    check(sdo, 1'b0, "R3 upstream busy", p);
    tick(30);
    check(sdo, 1'b1, "R4 chain ready", p);
    res_near = ~w[0]; res_mid = ~w[1]; res_far = ~w[2];
    if (p == 2) begin
      sdi_far = 1'b0; tick(12);
      check(sdo, 1'b0, "R4 upstream low", p);
      sdi_far = 1'b1; tick(12);
      check(sdo, 1'b1, "R4 upstream high", p);
    end
    for (int i = 0; i <= 3 * DW; i++) begin
      logic e;
      if (i == 0) e = 1'b1;
      else e = w[(i - 1) / DW][DW - 1 - ((i - 1) % DW)];
      if (i == 0) check(sdo, e, "R4 ready bit", i);
      else if (i <= DW) check(sdo, e, "R5 local MSB first", i);
      else check(sdo, e, "R6 upstream passthrough / R8 captured", i);
      sck = 1'b0; tick(8);
      sck = 1'b1; tick(8);
    end
    cnv = 1'b0; sdi_far = 1'b0;
    tick(10);
    check(sdo, 1'b0, "R7 end of frame", p);
    check(sdo, 1'b0, "R1 cnv and sdi low", p);
  endtask

  initial begin
    tick(5);
    check(sdo, 1'b0, "R1 in reset", 0);
    rst_n = 1'b1;
    tick(5);
    check(sdo, 1'b0, "R1 idle", 0);

    sck = 1'b0; tick(4);
    cnv = 1'b1; sdi_far = 1'b1;
    tick(120);
    check(sdo, 1'b0, "R2 cnv rise with sck low", 0);
    sck = 1'b1; tick(40);
    check(sdo, 1'b0, "R2 no late start", 1);
    cnv = 1'b0; sdi_far = 1'b0; tick(10);

    sck = 1'b1; tick(4);
    cnv = 1'b1; sdi_far = 1'b1;
    tick(30);
    cnv = 1'b0; sdi_far = 1'b0;
    tick(10);
    check(sdo, 1'b0, "R7 abort in conversion", 0);
    tick(100);
    check(sdo, 1'b0, "R7 stays idle", 1);

    for (int p = 0; p < 8; p++) run_frame(p);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule